// File: doc/BRIEF.md
# Streaming Two-Half Sector Parity Generator

This block builds single-error-correcting Hamming check bits for a 512-byte flash sector while the sector's bytes pass through the flash data path. The sector is handled as two independent 256-byte halves, and each half gets a 3-byte code made of 16 line parity bits and 6 column parity bits. A host steers it with 8-bit mode commands. One command clears the accumulators. One enables accumulation. One turns the readback port into a result window. One returns the block to plain data mode.

After a clear command the first data strobe is treated as a throw-away access and never reaches the parity. Accumulation then fills the first half's code for bytes 0 to 255 and the second half's for bytes 256 to 511, and it stops after that. In result mode the six code bytes come out as three interleaved 16-bit words, one per read strobe.

Top module: `ecc_stream_gen`

## Requirements
- R1: After the reset input is released, `rd_word` is 0x0000 and the block is in data mode. The results of an empty sector read as 0x0000, 0x0003, 0x0300.
- R2: Mode value 0xF4 clears both halves' codes and the byte counter. After it, the result words read 0x0000, 0x0003, 0x0300 again.
- R3: The first `byte_vld` strobe after a 0xF4 command is discarded in any mode. This holds even when calculation is already enabled, in which case that byte adds no parity.
- R4: Mode value 0xB4 enables accumulation. Bytes strobed in any other mode change neither code.
- R5: Within a half, a byte at half-address a with XOR-of-bits p toggles line bit 2k+1 by p when bit k of a is 1, and line bit 2k by p when it is 0, for k = 0..7.
- R6: Bit j of every accumulated byte toggles column bit 2k+1 when bit k of j is 1, and column bit 2k when it is 0, for k = 0..2. A half's column byte is {CP5..CP0, 1, 1}, with bits 1:0 fixed at 1.
- R7: Accepted bytes 0 to 255 update only the first half's code. Bytes 256 to 511 update only the second half's code.
- R8: After 512 accepted bytes, further bytes are ignored until the next 0xF4.
- R9: Mode value 0xD4 enters result mode at word 0. Each `word_rd` advances one word. Word 0 is {h0 LP15:8, h0 LP7:0}, word 1 is {h1 LP7:0, h0 column byte}, and word 2 is {h1 column byte, h1 LP15:8}, each with the first-named field as the high byte.
- R10: Reads past the third word repeat the third word. A read taken before 512 bytes returns the current partial codes.
- R11: Mode value 0x94 returns the block to data mode, where `rd_word` is 0x0000. Any mode value other than 0x94, 0xB4, 0xD4 and 0xF4 leaves the mode and word index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode command strobe |
| mode_val | input | 8 | Mode command value |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| word_rd | input | 1 | Result word read strobe |
| rd_word | output | 16 | Result word (0 outside result mode) |

## Verification
The bench applies four kinds of sector. A full pseudo-random sector checks that every line and column bit is placed correctly across the three words. A sector that is zero except for one set bit in the second half shows whether the halves are split at byte 256 and whether the interleaving routes each field to the right word. A short sector, read mid-way, with bytes slipped in while in data mode, separates partial-state readback from the ignore rule. An over-long sector of 600 bytes, and a clear command followed directly by calculation, expose a counter that fails to stop or a throw-away byte that leaks into the parity.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;
  localparam int BYTE_W      = 8;
  localparam int HALF_ADDR_W = 8;
  localparam int NUM_HALVES  = 2;
  localparam int LP_W        = 2 * HALF_ADDR_W;
  localparam int CP_W        = 2 * $clog2(BYTE_W);
  localparam int CNT_W       = HALF_ADDR_W + $clog2(NUM_HALVES) + 1;
  localparam int WORD_W      = 16;

  localparam logic [7:0] CMD_DATA   = 8'h94;
  localparam logic [7:0] CMD_CLEAR  = 8'hF4;
  localparam logic [7:0] CMD_CALC   = 8'hB4;
  localparam logic [7:0] CMD_RESULT = 8'hD4;

  typedef enum logic [1:0] {
    M_DATA   = 2'd0,
    M_CLEAR  = 2'd1,
    M_CALC   = 2'd2,
    M_RESULT = 2'd3
  } ecc_mode_e;

  typedef struct packed {
    logic [LP_W-1:0] lp;
    logic [CP_W-1:0] cp;
  } half_code_t;
endpackage

// File: rtl/ecc_byte_term.sv
module ecc_byte_term
  import ecc_gen_pkg::*;
(
  input  logic [BYTE_W-1:0]      data,
  input  logic [HALF_ADDR_W-1:0] addr,
  output half_code_t             term
);
  localparam int COL_K = CP_W / 2;

  logic            par;
  logic [LP_W-1:0] lp_t;
  logic [CP_W-1:0] cp_t;

  assign par = ^data;

  // Line parity: address bit k selects the odd or even bit of pair k.
  for (genvar k = 0; k < HALF_ADDR_W; k++) begin : g_line
    assign lp_t[2*k+1] = par & addr[k];
    assign lp_t[2*k]   = par & ~addr[k];
  end

  // Column parity: bit index bit k selects the odd or even bit of pair k.
  always_comb begin
    cp_t = '0;
    for (int j = 0; j < BYTE_W; j++) begin
      for (int k = 0; k < COL_K; k++) begin
        if (((j >> k) & 1) != 0) cp_t[2*k+1] = cp_t[2*k+1] ^ data[j];
        else                     cp_t[2*k]   = cp_t[2*k]   ^ data[j];
      end
    end
  end

  assign term.lp = lp_t;
  assign term.cp = cp_t;
endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import ecc_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  half_code_t term,
  output half_code_t code
);
  half_code_t code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (clr)     code_d = '0;
    else if (en) code_d = code_q ^ term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/ecc_word_mux.sv
module ecc_word_mux
  import ecc_gen_pkg::*;
(
  input  half_code_t        h0,
  input  half_code_t        h1,
  input  logic [1:0]        idx,
  input  logic              active,
  output logic [WORD_W-1:0] word
);
  logic [7:0] col0, col1;

  assign col0 = {h0.cp, 2'b11};
  assign col1 = {h1.cp, 2'b11};

  always_comb begin
    word = '0;
    if (active) begin
      case (idx)
        2'd0:    word = {h0.lp[15:8], h0.lp[7:0]};
        2'd1:    word = {h1.lp[7:0],  col0};
        default: word = {col1,        h1.lp[15:8]};
      endcase
    end
  end
endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
  import ecc_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [7:0]        mode_val,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              word_rd,
  output logic [WORD_W-1:0] rd_word
);
  localparam logic [1:0] LAST_IDX = 2'd2;

  ecc_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             skip_q, skip_d;
  logic [1:0]       idx_q, idx_d;
  logic             clr, take, done;
  logic             half_sel;
  half_code_t       term;
  half_code_t       codes [NUM_HALVES];

  assign done     = cnt_q[CNT_W-1];
  assign half_sel = cnt_q[HALF_ADDR_W];
  assign take     = byte_vld && (mode_q == M_CALC) && !skip_q && !done;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    skip_d = skip_q;
    idx_d  = idx_q;
    clr    = 1'b0;
    if (byte_vld) skip_d = 1'b0;
    if (take) cnt_d = cnt_q + 1'b1;
    if (word_rd && (mode_q == M_RESULT) && (idx_q != LAST_IDX))
      idx_d = idx_q + 2'd1;
    if (mode_wr) begin
      case (mode_val)
        CMD_CLEAR: begin
          mode_d = M_CLEAR;
          cnt_d  = '0;
          skip_d = 1'b1;
          clr    = 1'b1;
        end
        CMD_CALC:   mode_d = M_CALC;
        CMD_RESULT: begin
          mode_d = M_RESULT;
          idx_d  = '0;
        end
        CMD_DATA:   mode_d = M_DATA;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_DATA;
      cnt_q  <= '0;
      skip_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      skip_q <= skip_d;
      idx_q  <= idx_d;
    end
  end

  ecc_byte_term u_term (
    .data (byte_in),
    .addr (cnt_q[HALF_ADDR_W-1:0]),
    .term (term)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    ecc_half_acc u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (take && (half_sel == h[0])),
      .term  (term),
      .code  (codes[h])
    );
  end

  ecc_word_mux u_mux (
    .h0     (codes[0]),
    .h1     (codes[1]),
    .idx    (idx_q),
    .active (mode_q == M_RESULT),
    .word   (rd_word)
  );
endmodule

// File: rtl/ecc_stream_gen_chk.sv
module ecc_stream_gen_chk
  import ecc_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [7:0]        mode_val,
  input  logic              byte_vld,
  input  logic              word_rd,
  input  logic [WORD_W-1:0] rd_word,
  input  ecc_mode_e         mode_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              skip_q,
  input  logic [1:0]        idx_q
);
  // R2
  clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val == CMD_CLEAR) |=> (cnt_q == '0 && skip_q));

  // R3
  skip_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && byte_vld && !mode_wr) |=> !skip_q);

  // R8
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NUM_HALVES << HALF_ADDR_W));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(byte_vld && mode_q == M_CALC) && !mode_wr) |=> $stable(cnt_q));

  // R10
  idx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q != 2'd3);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RESULT && !word_rd && !mode_wr && !byte_vld) |=> $stable(rd_word));

  // R11
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val != CMD_CLEAR && mode_val != CMD_CALC &&
     mode_val != CMD_RESULT && mode_val != CMD_DATA && !word_rd) |=>
    ($stable(mode_q) && $stable(idx_q)));
endmodule

bind ecc_stream_gen ecc_stream_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_wr  (mode_wr),
  .mode_val (mode_val),
  .byte_vld (byte_vld),
  .word_rd  (word_rd),
  .rd_word  (rd_word),
  .mode_q   (mode_q),
  .cnt_q    (cnt_q),
  .skip_q   (skip_q),
  .idx_q    (idx_q)
);

// File: tb/tb_ecc_stream_gen.sv
module tb_ecc_stream_gen;
  logic        clk;
  logic        rst_n;
  logic        mode_wr;
  logic [7:0]  mode_val;
  logic        byte_vld;
  logic [7:0]  byte_in;
  logic        word_rd;
  logic [15:0] rd_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench-side model state, derived from the requirements
  logic [7:0]  m_bytes[$];
  logic [15:0] exp_q[$];
  string       tag_q[$];
  int          m_mode = 0;   // 0 data, 1 clear, 2 calc, 3 result
  bit          m_skip = 0;
  int          m_idx  = 0;

  ecc_stream_gen dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .mode_val (mode_val),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .word_rd  (word_rd),
    .rd_word  (rd_word)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [15:0] ref_word(int idx);
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    logic [7:0]  c0, c1;
    lp[0] = '0; lp[1] = '0; cp[0] = '0; cp[1] = '0;
    for (int n = 0; n < m_bytes.size(); n++) begin
      int h = n / 256;
      int a = n % 256;
      for (int j = 0; j < 8; j++) begin
        if (m_bytes[n][j]) begin
          for (int k = 0; k < 8; k++) lp[h][2*k + ((a >> k) & 1)] ^= 1'b1;
          for (int k = 0; k < 3; k++) cp[h][2*k + ((j >> k) & 1)] ^= 1'b1;
        end
      end
    end
    c0 = {cp[0], 2'b11};
    c1 = {cp[1], 2'b11};
    case (idx)
      0:       return {lp[0][15:8], lp[0][7:0]};
      1:       return {lp[1][7:0], c0};
      default: return {c1, lp[1][15:8]};
    endcase
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic send_mode(input logic [7:0] v);
    mode_wr = 1; mode_val = v;
    case (v)
      8'hF4: begin m_mode = 1; m_bytes.delete(); m_skip = 1; end
      8'hB4: m_mode = 2;
      8'hD4: begin m_mode = 3; m_idx = 0; end
      8'h94: m_mode = 0;
      default: ;
    endcase
    @(posedge clk); #1;
    mode_wr = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_vld = 1; byte_in = b;
    if (m_skip) m_skip = 0;
    else if (m_mode == 2 && m_bytes.size() < 512) m_bytes.push_back(b);
    @(posedge clk); #1;
    byte_vld = 0;
  endtask

  task automatic read_word(input string tag);
    exp_q.push_back(ref_word(m_idx));
    tag_q.push_back(tag);
    word_rd = 1;
    @(posedge clk); #1;
    word_rd = 0;
    if (m_idx < 2) m_idx++;
  endtask

  task automatic check_now(input logic [15:0] exp, input string tag);
    @(negedge clk);
    n_checks++;
    if (rd_word !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_word actual=%h expected=%h", tag, rd_word, exp);
    end
    @(posedge clk); #1;
  endtask

  // monitor: compare every read against the scoreboard queue
  always @(negedge clk) begin
    if (word_rd && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rd_word !== e) begin
        n_fail++;
        $display("FAIL %s: rd_word actual=%h expected=%h", t, rd_word, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    rst_n = 0; mode_wr = 0; mode_val = '0; byte_vld = 0; byte_in = '0; word_rd = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1: reset state and empty results
    check_now(16'h0000, "R1 reset output");
    send_mode(8'hD4);
    read_word("R1 empty w0");
    read_word("R1 empty w1");
    read_word("R1 empty w2");

    // R5 R6 R9 R10: full pseudo-random sector
    send_mode(8'hF4);
    send_byte(8'hFF);
    send_mode(8'hB4);
    for (int i = 0; i < 512; i++) send_byte(8'((i * 37 + 11) & 255));
    send_mode(8'hD4);
    read_word("R5 R9 word0");
    read_word("R6 R9 word1");
    read_word("R6 R9 word2");
    read_word("R10 fourth read");

    // R7: single set bit in second half
    send_mode(8'hF4);
    send_byte(8'h00);
    send_mode(8'hB4);
    for (int i = 0; i < 512; i++) send_byte((i == 300) ? 8'h20 : 8'h00);
    send_mode(8'hD4);
    read_word("R7 word0");
    read_word("R7 word1");
    read_word("R7 word2");

    // R3: calc enabled right after clear, first byte dropped
    send_mode(8'hF4);
    send_mode(8'hB4);
    for (int i = 0; i < 10; i++) send_byte(8'hA5 ^ 8'(i));
    send_mode(8'hD4);
    read_word("R3 R10 partial w0");
    read_word("R3 R10 partial w1");
    read_word("R3 R10 partial w2");

    // R11: data mode output; R4: bytes in data mode ignored
    send_mode(8'h94);
    check_now(16'h0000, "R11 data mode output");
    for (int i = 0; i < 5; i++) send_byte(8'h3C + 8'(i));
    send_mode(8'hD4);
    read_word("R4 ignored w0");
    read_word("R4 ignored w1");
    read_word("R4 ignored w2");

    // R11: unknown mode value keeps result mode and index
    send_mode(8'hD4);
    read_word("R11 pre w0");
    send_mode(8'h55);
    read_word("R11 unknown cmd w1");

    // R8: over-long sector
    send_mode(8'hF4);
    send_byte(8'h77);
    send_mode(8'hB4);
    for (int i = 0; i < 600; i++) send_byte(8'(i) ^ 8'h5A);
    send_mode(8'hD4);
    read_word("R8 w0");
    read_word("R8 w1");
    read_word("R8 w2");

    // R2: clear resets codes
    send_mode(8'hF4);
    send_mode(8'hD4);
    check_now(16'h0000, "R2 cleared w0 direct");
    read_word("R2 cleared w0");
    read_word("R2 cleared w1");
    read_word("R2 cleared w2");

    repeat (3) @(posedge clk);
    finish_up();
  end
endmodule